// File: doc/BRIEF.md
# Shared-Chain Adder-Subtractor ALU

This block is the combinational arithmetic-logic unit of a 32-bit integer datapath. It takes two operands and a three-bit operation code. It returns a result word, a carry-out, a signed overflow flag and a zero flag. There is no clock and no reset; every output follows the inputs through gates only.

Addition and subtraction use the same ripple chain of one-bit full-adder cells. Each bit of the second operand passes through an XOR gate whose other input is the subtract control. The same control drives the carry-in of the lowest cell, so subtraction is computed as a + ~b + 1. Signed set-less-than reuses that subtraction and corrects the sign bit with the overflow flag. The zero flag lets a branch unit test two registers for equality by subtracting them.

Top module: `addsub_alu`

## Requirements
- R1: Op code 3'b000 returns the bitwise AND of a_i and b_i, with carry_o and ovf_o at 0.
- R2: Op code 3'b001 returns the bitwise OR of a_i and b_i, with carry_o and ovf_o at 0.
- R3: Op code 3'b010 returns (a_i + b_i) mod 2^32, and carry_o is the carry out of the top cell.
- R4: Op code 3'b110 returns (a_i - b_i) mod 2^32, and carry_o is 1 exactly when a_i >= b_i as unsigned numbers (no borrow).
- R5: For ADD and SUB, ovf_o is 1 exactly when the true signed result does not fit in 32 bits. For SLT it reports the overflow of the internal subtraction.
- R6: Op code 3'b111 returns 1 in bit 0 when a_i < b_i as signed two's-complement numbers and 0 otherwise, with bits 31..1 at 0. The answer stays correct when a_i - b_i overflows. For SLT, carry_o reports the carry of the internal subtraction.
- R7: zero_o is 1 exactly when all 32 bits of result_o are 0, for every op code.
- R8: The unused op codes 3'b011, 3'b100 and 3'b101 give result_o = 0, carry_o = 0 and ovf_o = 0, and therefore zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, conditionally inverted for subtraction |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Carry out of the most significant adder cell |
| ovf_o | output | 1 | Signed overflow of ADD, SUB or SLT |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench aims at the carry chain at full length. It adds 0xFFFFFFFF and 1, and a broken ripple link would leave stray ones or lose the carry-out. It drives signed overflow both ways (0x7FFFFFFF + 1 and 0x80000000 - 1), where an overflow flag taken from the final carry alone would be wrong. It also runs set-less-than on operands whose difference overflows: a compare that reads only the sign of the difference gives the inverted answer there. Subtracting equal values and using the reserved op codes show whether the carry-in is forced high for subtraction and whether unused codes leak an adder result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 3;

  // op[2] selects inversion of b in the adder chain; SLT shares it with SUB
  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   c;
  logic [WIDTH-1:0] b_x;

  assign c[0] = sub_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    assign b_x[g] = b_i[g] ^ sub_i;
    alu_full_adder i_fa (
      .a_i (a_i[g]),
      .b_i (b_x[g]),
      .c_i (c[g]),
      .s_o (sum_o[g]),
      .c_o (c[g+1])
    );
  end

  assign carry_o = c[WIDTH];
  assign ovf_o   = c[WIDTH] ^ c[MSB];

  // ripple chain against a wide behavioural sum
  logic [WIDTH:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, a_i} + {1'b0, (sub_i ? ~b_i : b_i)} + {{WIDTH{1'b0}}, sub_i};
    assert_chain_sum_R3: assert ({carry_o, sum_o} == ref_sum)
      else $error("adder chain mismatch");
    // sign rule: same-sign inputs giving a different-sign sum
    assert_sign_ovf_R5: assert (ovf_o == ((a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB])))
      else $error("overflow flag mismatch");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             or_sel_i,
  output logic [WIDTH-1:0] y_o
);
  assign y_o = or_sel_i ? (a_i | b_i) : (a_i & b_i);
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             sub_en;
  logic [WIDTH-1:0] sum;
  logic             sum_c;
  logic             sum_v;
  logic [WIDTH-1:0] lgc;
  logic             less;

  assign sub_en = (op_i == OP_SUB) || (op_i == OP_SLT);

  alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_en),
    .sum_o   (sum),
    .carry_o (sum_c),
    .ovf_o   (sum_v)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .or_sel_i (op_i[0]),
    .y_o      (lgc)
  );

  // difference sign corrected by overflow
  assign less = sum[MSB] ^ sum_v;

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    ovf_o    = 1'b0;
    case (op_i)
      OP_AND, OP_OR: result_o = lgc;
      OP_ADD, OP_SUB: begin
        result_o = sum;
        carry_o  = sum_c;
        ovf_o    = sum_v;
      end
      OP_SLT: begin
        result_o = {{(WIDTH-1){1'b0}}, less};
        carry_o  = sum_c;
        ovf_o    = sum_v;
      end
      default: ;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    assert_slt_sign_R6: assert ((op_i != OP_SLT) || (result_o[0] == ($signed(a_i) < $signed(b_i))))
      else $error("signed compare wrong");
    assert_slt_upper_R6: assert ((op_i != OP_SLT) || (result_o[MSB:1] == '0))
      else $error("compare upper bits set");
    assert_rsvd_quiet_R8: assert (!((op_i == 3'b011) || (op_i == 3'b100) || (op_i == 3'b101))
                                  || (zero_o && !carry_o && !ovf_o))
      else $error("reserved code leaked");
    assert_logic_flags_R1: assert (!((op_i == OP_AND) || (op_i == OP_OR)) || (!carry_o && !ovf_o))
      else $error("logic op raised a flag");
  end
endmodule

// File: tb/test_addsub_alu.sv
`timescale 1ns/1ps
module test_addsub_alu;
  localparam int W = 32;

  typedef struct packed {
    logic [W-1:0] res;
    logic         c;
    logic         v;
    logic         z;
  } exp_t;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic         carry, ovf, zero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  addsub_alu i_addsub_alu (
    .a_i (a), .b_i (b), .op_i (op),
    .result_o (result), .carry_o (carry), .ovf_o (ovf), .zero_o (zero)
  );

  function automatic exp_t model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    exp_t e;
    logic [W:0] s;
    e = '0;
    case (o)
      3'b000: e.res = x & y;                         // R1
      3'b001: e.res = x | y;                         // R2
      3'b010: begin                                  // R3, R5
        s = {1'b0, x} + {1'b0, y};
        e.res = s[W-1:0]; e.c = s[W];
        e.v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      end
      3'b110, 3'b111: begin                          // R4, R5, R6
        s = {1'b0, x} - {1'b0, y};
        e.c = (x >= y);
        e.v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
        e.res = (o == 3'b110) ? s[W-1:0] : {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      end
      default: e.res = '0;                           // R8
    endcase
    e.z = (e.res == '0);                             // R7
    return e;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    @(posedge clk);
    op <= o; a <= x; b <= y;
    exp_q.push_back(model(o, x, y));
    tag_q.push_back(tag);
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      exp_t got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = '{res: result, c: carry, v: ovf, z: zero};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s op=%b a=%h b=%h: got res=%h c=%b v=%b z=%b, expected res=%h c=%b v=%b z=%b",
                 t, op, a, b, got.res, got.c, got.v, got.z, e.res, e.c, e.v, e.z);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; op = 3'b000;
    // initial state: AND of zeros, zero flag set (R7)
    drive(3'b000, 32'h0, 32'h0, "R7 idle");
    drive(3'b000, 32'hF0F0_A5A5, 32'h0FF0_FFFF, "R1 and");
    drive(3'b001, 32'hF000_0001, 32'h0000_1000, "R2 or");
    drive(3'b001, 32'h0, 32'h0, "R2 or zero R7");
    drive(3'b010, 32'hFFFF_FFFF, 32'h1, "R3 full ripple carry R7");
    drive(3'b010, 32'h7FFF_FFFF, 32'h1, "R5 add pos overflow");
    drive(3'b010, 32'h8000_0000, 32'h8000_0000, "R5 add neg overflow");
    drive(3'b110, 32'h8000_0000, 32'h1, "R5 sub overflow");
    drive(3'b110, 32'h1234_5678, 32'h1234_5678, "R4 equal R7");
    drive(3'b110, 32'h0, 32'h1, "R4 borrow");
    drive(3'b111, 32'h8000_0000, 32'h1, "R6 slt overflow true");
    drive(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R6 slt overflow false");
    drive(3'b111, 32'hFFFF_FFFF, 32'h0, "R6 slt negative");
    drive(3'b111, 32'h5, 32'h5, "R6 slt equal");
    drive(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 reserved 011");
    drive(3'b100, 32'h8000_0000, 32'h8000_0000, "R8 reserved 100");
    drive(3'b101, 32'hDEAD_BEEF, 32'h1, "R8 reserved 101");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      logic [W-1:0] x, y;
      o = 3'($urandom_range(0, 7));
      x = $urandom;
      y = (i % 4 == 0) ? x : $urandom;
      drive(o, x, y, "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule